// File: doc/BRIEF.md
# Bounded Depth-First Edge Scheduler

This block walks a graph held in compressed sparse row form and hands out its edges in an order that keeps neighbouring vertices close together in time. It does not scan vertices in plain id order. It runs a series of depth-first explorations whose depth is capped by a programmable limit. Every edge is produced exactly once, so the edges of one densely linked group of vertices come out together before the walk moves to the next group.

Software sets up the traversal and pulses `start`. The configuration is the word address of the offset array, the word address of the neighbour array, the vertex count and the depth limit. The block then reads the offsets and neighbours through a single-outstanding read port. It keeps a stack of suspended exploration frames and a visited bit per vertex. Each edge, written as (source, destination), goes into a small output queue that the processing core drains with a valid/ready handshake. In the same cycle that an edge is queued, the block issues a prefetch hint that carries the destination vertex id. `done` rises once every vertex has been covered.

Top module: `bdfs_scheduler`

## Requirements
- R1: Out of reset, `busy`, `done`, `edge_valid`, `rd_req_valid` and `pf_valid` are all 0.
- R2: The offsets of vertex v are read from word addresses `cfg_offset_base`+v and `cfg_offset_base`+v+1. Neighbour k is read from `cfg_neighbor_base`+k. Only one read is outstanding at a time. A request holds its address until `rd_req_ready`. A complete traversal issues exactly 2·N + E reads, where N is the vertex count and E is the edge count.
- R3: The first exploration starts at vertex 0. An edge (u,d) is queued before any edge of d. If d is unvisited and the live depth (suspended frames + 1) is below the limit, d becomes the new active vertex and is marked visited. Otherwise u continues with its next neighbour. When a vertex runs out of neighbours, its parent resumes at the neighbour that follows the one it descended through.
- R4: Every edge in the neighbour array is queued exactly once, including edges to visited vertices and edges that are cut off by the depth limit.
- R5: Each queued edge is accompanied, in that same cycle, by a one-cycle `pf_valid` with `pf_vertex` equal to its destination. The sequence of prefetch hints matches the sequence of edges.
- R6: A depth limit of 1, or of 0 (which is treated as 1), yields plain vertex order: every vertex in id order, each with its own edges.
- R7: A depth limit above `STACK_DEPTH` behaves as a limit of `STACK_DEPTH`.
- R8: While the edge queue is full, the walk stalls with no edge lost or repeated, and the edge order is unchanged by backpressure on either `edge_ready` or `rd_req_ready`.
- R9: When the exploration stack is empty, the next root is the lowest-id unvisited vertex. `done` rises, and `busy` falls, after the last vertex has been passed. A vertex count of 0 gives `done` with no edges. Vertices with no neighbours give no edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a traversal (accepted when not busy) |
| cfg_offset_base | input | ADDR_W | Word address of the offset array |
| cfg_neighbor_base | input | ADDR_W | Word address of the neighbour array |
| cfg_num_vertices | input | VID_W+1 | Vertex count (clamped to MAX_VERTICES) |
| cfg_depth_bound | input | BOUND_W | Exploration depth limit |
| rd_req_valid | output | 1 | Read request |
| rd_req_addr | output | ADDR_W | Read word address |
| rd_req_ready | input | 1 | Memory accepts the request |
| rd_rsp_valid | input | 1 | Read data returned |
| rd_rsp_data | input | DATA_W | Read data |
| edge_valid | output | 1 | Edge queue not empty |
| edge_src | output | VID_W | Source vertex of head edge |
| edge_dst | output | VID_W | Destination vertex of head edge |
| edge_ready | input | 1 | Core takes the head edge |
| pf_valid | output | 1 | Destination prefetch hint |
| pf_vertex | output | VID_W | Vertex to prefetch |
| busy | output | 1 | Traversal in progress |
| done | output | 1 | Traversal complete |

## Verification
Prefetch hints are combinational in the cycle in which an edge enters the queue. The queued edge appears on `edge_valid` one edge later. Every read response is taken on the edge that follows acceptance. The bench therefore samples all outputs on the falling clock. It records a hint in the same half-cycle as the queue write and records an edge in the half-cycle before the rising edge that pops it, so each result is taken in the cycle it is due rather than after some settling delay. `done` is checked after the final hint has been recorded, and the bench compares whole edge and hint sequences against an order it builds from R3 alone. Read requests are counted at acceptance and compared with 2·N + E.

// File: rtl/bdfs_pkg.sv
package bdfs_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ROOT,
    ST_OLO_REQ,
    ST_OLO_WAIT,
    ST_OHI_REQ,
    ST_OHI_WAIT,
    ST_NEXT,
    ST_NBR_REQ,
    ST_NBR_WAIT,
    ST_EMIT,
    ST_DONE
  } walk_state_e;

endpackage

// File: rtl/bdfs_visited.sv
module bdfs_visited #(
  parameter int N    = 64,
  parameter int IW   = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          set_en,
  input  logic [IW-1:0] set_idx,
  input  logic [IW-1:0] rd_a_idx,
  output logic          rd_a,
  input  logic [IW-1:0] rd_b_idx,
  output logic          rd_b
);

  logic [N-1:0] bits_q;

  for (genvar i = 0; i < N; i++) begin : g_bit
    logic bit_en, bit_d;
    assign bit_en = clr | (set_en && (set_idx == IW'(i)));
    assign bit_d  = ~clr;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      bits_q[i] <= 1'b0;
      else if (bit_en) bits_q[i] <= bit_d;
    end
  end

  assign rd_a = bits_q[rd_a_idx];
  assign rd_b = bits_q[rd_b_idx];

  AST_MARK_FRESH: assert property (@(posedge clk) disable iff (!rst_n)
    set_en |-> !bits_q[set_idx]);  // R3

endmodule

// File: rtl/bdfs_frame_stack.sv
module bdfs_frame_stack #(
  parameter int DEPTH = 8,
  parameter int FW    = 38,
  parameter int LW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          push,
  input  logic          pop,
  input  logic [FW-1:0] din,
  output logic [FW-1:0] dout,
  output logic [LW-1:0] level
);

  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [FW-1:0] mem_q [DEPTH];
  logic [LW-1:0] level_q, level_d;
  logic [IW-1:0] wr_idx, rd_idx;

  assign wr_idx = IW'(level_q);
  assign rd_idx = IW'(level_q - LW'(1));
  assign dout   = mem_q[rd_idx];
  assign level  = level_q;

  always_comb begin
    level_d = level_q;
    if (clr)       level_d = '0;
    else if (push) level_d = level_q + LW'(1);
    else if (pop)  level_d = level_q - LW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) level_q <= '0;
    else        level_q <= level_d;
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (push && !clr && (wr_idx == IW'(i))) mem_q[i] <= din;
    end
  end

  AST_STACK_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> (level_q < LW'(DEPTH)));  // R7
  AST_STACK_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> (level_q != '0));  // R3

endmodule

// File: rtl/bdfs_edge_fifo.sv
module bdfs_edge_fifo #(
  parameter int DEPTH = 4,
  parameter int W     = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] din,
  output logic         full,
  input  logic         pop_req,
  output logic [W-1:0] dout,
  output logic         empty
);

  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem_q [DEPTH];
  logic [PW-1:0] wp_q, wp_d, rp_q, rp_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          do_pop, do_push;

  assign empty   = (cnt_q == '0);
  assign full    = (cnt_q == CW'(DEPTH));
  assign do_pop  = pop_req && !empty;
  assign do_push = push;
  assign dout    = mem_q[rp_q];

  always_comb begin
    wp_d  = wp_q;
    rp_d  = rp_q;
    cnt_d = cnt_q;
    if (do_push) wp_d = (wp_q == PW'(DEPTH - 1)) ? '0 : wp_q + PW'(1);
    if (do_pop)  rp_d = (rp_q == PW'(DEPTH - 1)) ? '0 : rp_q + PW'(1);
    if (do_push && !do_pop)      cnt_d = cnt_q + CW'(1);
    else if (do_pop && !do_push) cnt_d = cnt_q - CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      wp_q  <= wp_d;
      rp_q  <= rp_d;
      cnt_q <= cnt_d;
    end
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (do_push && (wp_q == PW'(i))) mem_q[i] <= din;
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full);  // R8

endmodule

// File: rtl/bdfs_scheduler.sv
module bdfs_scheduler
  import bdfs_pkg::*;
#(
  parameter int MAX_VERTICES = 64,
  parameter int STACK_DEPTH  = 8,
  parameter int FIFO_DEPTH   = 4,
  parameter int ADDR_W       = 16,
  parameter int DATA_W       = 16,
  parameter int BOUND_W      = 8,
  parameter int VID_W        = $clog2(MAX_VERTICES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [ADDR_W-1:0]  cfg_offset_base,
  input  logic [ADDR_W-1:0]  cfg_neighbor_base,
  input  logic [VID_W:0]     cfg_num_vertices,
  input  logic [BOUND_W-1:0] cfg_depth_bound,
  output logic               rd_req_valid,
  output logic [ADDR_W-1:0]  rd_req_addr,
  input  logic               rd_req_ready,
  input  logic               rd_rsp_valid,
  input  logic [DATA_W-1:0]  rd_rsp_data,
  output logic               edge_valid,
  output logic [VID_W-1:0]   edge_src,
  output logic [VID_W-1:0]   edge_dst,
  input  logic               edge_ready,
  output logic               pf_valid,
  output logic [VID_W-1:0]   pf_vertex,
  output logic               busy,
  output logic               done
);

  localparam int CNT_W = VID_W + 1;
  localparam int LW    = $clog2(STACK_DEPTH + 1);
  localparam int FW    = VID_W + 2 * DATA_W;
  localparam int EW    = 2 * VID_W;

  walk_state_e        state_q, state_d;
  logic [ADDR_W-1:0]  obase_q, obase_d, nbase_q, nbase_d;
  logic [CNT_W-1:0]   nv_q, nv_d, root_q, root_d;
  logic [LW-1:0]      bound_q, bound_d;
  logic [VID_W-1:0]   cur_v_q, cur_v_d, nbr_q, nbr_d;
  logic [DATA_W-1:0]  cur_c_q, cur_c_d, cur_e_q, cur_e_d;

  logic               stk_clr, stk_push, stk_pop;
  logic [FW-1:0]      stk_din, stk_dout;
  logic [LW-1:0]      stk_level;
  logic               vis_clr, vis_set;
  logic [VID_W-1:0]   vis_idx;
  logic               root_seen, nbr_seen;
  logic               fifo_push, fifo_full, fifo_empty;
  logic [EW-1:0]      fifo_dout;
  logic [LW-1:0]      eff_bound;
  logic [CNT_W-1:0]   nv_clamped;

  // Configuration clamps applied when a traversal is launched.
  always_comb begin
    if (cfg_depth_bound == '0)                          eff_bound = LW'(1);
    else if (cfg_depth_bound > BOUND_W'(STACK_DEPTH))   eff_bound = LW'(STACK_DEPTH);
    else                                                eff_bound = LW'(cfg_depth_bound);
    nv_clamped = (cfg_num_vertices > CNT_W'(MAX_VERTICES)) ? CNT_W'(MAX_VERTICES)
                                                           : cfg_num_vertices;
  end

  bdfs_visited #(.N(MAX_VERTICES), .IW(VID_W)) u_visited (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (vis_clr),
    .set_en   (vis_set),
    .set_idx  (vis_idx),
    .rd_a_idx (root_q[VID_W-1:0]),
    .rd_a     (root_seen),
    .rd_b_idx (nbr_q),
    .rd_b     (nbr_seen)
  );

  bdfs_frame_stack #(.DEPTH(STACK_DEPTH), .FW(FW), .LW(LW)) u_stack (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (stk_clr),
    .push  (stk_push),
    .pop   (stk_pop),
    .din   (stk_din),
    .dout  (stk_dout),
    .level (stk_level)
  );

  bdfs_edge_fifo #(.DEPTH(FIFO_DEPTH), .W(EW)) u_fifo (
    .clk     (clk),
    .rst_n   (rst_n),
    .push    (fifo_push),
    .din     ({cur_v_q, nbr_q}),
    .full    (fifo_full),
    .pop_req (edge_ready),
    .dout    (fifo_dout),
    .empty   (fifo_empty)
  );

  assign edge_valid = !fifo_empty;
  assign edge_src   = fifo_dout[EW-1:VID_W];
  assign edge_dst   = fifo_dout[VID_W-1:0];
  assign pf_valid   = fifo_push;
  assign pf_vertex  = nbr_q;
  assign busy       = (state_q != ST_IDLE) && (state_q != ST_DONE);
  assign done       = (state_q == ST_DONE);
  assign stk_din    = {cur_v_q, cur_c_q + DATA_W'(1), cur_e_q};

  // Exploration sequencing: next-state and datapath selects.
  always_comb begin
    state_d      = state_q;
    obase_d      = obase_q;
    nbase_d      = nbase_q;
    nv_d         = nv_q;
    bound_d      = bound_q;
    root_d       = root_q;
    cur_v_d      = cur_v_q;
    cur_c_d      = cur_c_q;
    cur_e_d      = cur_e_q;
    nbr_d        = nbr_q;
    stk_clr      = 1'b0;
    stk_push     = 1'b0;
    stk_pop      = 1'b0;
    vis_clr      = 1'b0;
    vis_set      = 1'b0;
    vis_idx      = root_q[VID_W-1:0];
    fifo_push    = 1'b0;
    rd_req_valid = 1'b0;
    rd_req_addr  = obase_q + ADDR_W'(cur_v_q);

    unique case (state_q)
      ST_IDLE, ST_DONE: begin
        if (start) begin
          obase_d = cfg_offset_base;
          nbase_d = cfg_neighbor_base;
          nv_d    = nv_clamped;
          bound_d = eff_bound;
          root_d  = '0;
          stk_clr = 1'b1;
          vis_clr = 1'b1;
          state_d = ST_ROOT;
        end
      end
      ST_ROOT: begin
        if (root_q >= nv_q) begin
          state_d = ST_DONE;
        end else if (root_seen) begin
          root_d = root_q + CNT_W'(1);
        end else begin
          vis_set = 1'b1;
          cur_v_d = root_q[VID_W-1:0];
          state_d = ST_OLO_REQ;
        end
      end
      ST_OLO_REQ: begin
        rd_req_valid = 1'b1;
        if (rd_req_ready) state_d = ST_OLO_WAIT;
      end
      ST_OLO_WAIT: begin
        if (rd_rsp_valid) begin
          cur_c_d = rd_rsp_data;
          state_d = ST_OHI_REQ;
        end
      end
      ST_OHI_REQ: begin
        rd_req_valid = 1'b1;
        rd_req_addr  = obase_q + ADDR_W'(cur_v_q) + ADDR_W'(1);
        if (rd_req_ready) state_d = ST_OHI_WAIT;
      end
      ST_OHI_WAIT: begin
        if (rd_rsp_valid) begin
          cur_e_d = rd_rsp_data;
          state_d = ST_NEXT;
        end
      end
      ST_NEXT: begin
        if (cur_c_q == cur_e_q) begin
          if (stk_level == '0) begin
            state_d = ST_ROOT;
          end else begin
            stk_pop = 1'b1;
            {cur_v_d, cur_c_d, cur_e_d} = stk_dout;
          end
        end else begin
          state_d = ST_NBR_REQ;
        end
      end
      ST_NBR_REQ: begin
        rd_req_valid = 1'b1;
        rd_req_addr  = nbase_q + ADDR_W'(cur_c_q);
        if (rd_req_ready) state_d = ST_NBR_WAIT;
      end
      ST_NBR_WAIT: begin
        if (rd_rsp_valid) begin
          nbr_d   = rd_rsp_data[VID_W-1:0];
          state_d = ST_EMIT;
        end
      end
      ST_EMIT: begin
        if (!fifo_full) begin
          fifo_push = 1'b1;
          if (!nbr_seen && ((stk_level + LW'(1)) < bound_q)) begin
            stk_push = 1'b1;
            vis_set  = 1'b1;
            vis_idx  = nbr_q;
            cur_v_d  = nbr_q;
            state_d  = ST_OLO_REQ;
          end else begin
            cur_c_d  = cur_c_q + DATA_W'(1);
            state_d  = ST_NEXT;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      obase_q <= '0;
      nbase_q <= '0;
      nv_q    <= '0;
      bound_q <= '0;
      root_q  <= '0;
      cur_v_q <= '0;
      cur_c_q <= '0;
      cur_e_q <= '0;
      nbr_q   <= '0;
    end else begin
      state_q <= state_d;
      obase_q <= obase_d;
      nbase_q <= nbase_d;
      nv_q    <= nv_d;
      bound_q <= bound_d;
      root_q  <= root_d;
      cur_v_q <= cur_v_d;
      cur_c_q <= cur_c_d;
      cur_e_q <= cur_e_d;
      nbr_q   <= nbr_d;
    end
  end

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req_valid && !rd_req_ready) |=> (rd_req_valid && $stable(rd_req_addr)));  // R2
  AST_DEPTH_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (stk_level < bound_q));  // R7
  AST_STALL_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_EMIT && fifo_full) |=> ($stable(stk_level) && $stable(cur_v_q) && $stable(cur_c_q)));  // R8
  AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!rd_req_valid && !pf_valid && !busy));  // R9
  AST_PF_ONESHOT: assert property (@(posedge clk) disable iff (!rst_n)
    pf_valid |=> !pf_valid);  // R5

endmodule

// File: tb/bdfs_scheduler_bench.sv
module bdfs_scheduler_bench;

  localparam int VID_W = 6;
  localparam int SDEP  = 4;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              start;
  logic [15:0]       cfg_ob, cfg_nb;
  logic [VID_W:0]    cfg_nv;
  logic [7:0]        cfg_bd;
  logic              rd_req_valid, rd_req_ready, rd_rsp_valid;
  logic [15:0]       rd_req_addr, rd_rsp_data;
  logic              edge_valid, edge_ready, pf_valid, busy, done;
  logic [VID_W-1:0]  edge_src, edge_dst, pf_vertex;

  always #2.5 clk = ~clk;

  bdfs_scheduler #(.MAX_VERTICES(64), .STACK_DEPTH(SDEP), .FIFO_DEPTH(4)) u_bdfs_scheduler (
    .clk(clk), .rst_n(rst_n), .start(start),
    .cfg_offset_base(cfg_ob), .cfg_neighbor_base(cfg_nb),
    .cfg_num_vertices(cfg_nv), .cfg_depth_bound(cfg_bd),
    .rd_req_valid(rd_req_valid), .rd_req_addr(rd_req_addr), .rd_req_ready(rd_req_ready),
    .rd_rsp_valid(rd_rsp_valid), .rd_rsp_data(rd_rsp_data),
    .edge_valid(edge_valid), .edge_src(edge_src), .edge_dst(edge_dst), .edge_ready(edge_ready),
    .pf_valid(pf_valid), .pf_vertex(pf_vertex), .busy(busy), .done(done));

  logic [15:0] mem [256];
  int n_cmp = 0, n_bad = 0;
  int bp_mode = 0, cyc = 0;
  int got_n, pf_n, req_n;
  int got_s [256], got_d [256], pf_d [256];
  int exp_n;
  int exp_s [256], exp_d [256];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Memory model: one outstanding read, data one cycle after acceptance.
  always @(posedge clk) begin
    rd_rsp_valid <= rd_req_valid && rd_req_ready;
    rd_rsp_data  <= mem[rd_req_addr[7:0]];
  end

  // Sample and drive handshakes on the falling edge.
  always @(negedge clk) begin
    cyc++;
    if (pf_valid) begin pf_d[pf_n] = int'(pf_vertex); pf_n++; end
    edge_ready   = (bp_mode == 0) ? 1'b1 : ((cyc % 7) == 0);
    rd_req_ready = (bp_mode == 0) ? 1'b1 : ((cyc % 3) != 0);
    if (edge_valid && edge_ready) begin
      got_s[got_n] = int'(edge_src); got_d[got_n] = int'(edge_dst); got_n++;
    end
    if (rd_req_valid && rd_req_ready) req_n++;
  end

  // Expected order built directly from the bounded depth-first rule.
  task automatic build_ref(input int ob, input int nb, input int nv, input int bd);
    bit vis [64];
    int fv [8], fc [8], fe [8];
    int sp, v, c, e, d, eb;
    eb = (bd == 0) ? 1 : (bd > SDEP ? SDEP : bd);
    exp_n = 0;
    for (int i = 0; i < 64; i++) vis[i] = 1'b0;
    for (int r = 0; r < nv; r++) begin
      if (!vis[r]) begin
        vis[r] = 1'b1; sp = 0;
        v = r; c = int'(mem[ob + r]); e = int'(mem[ob + r + 1]);
        forever begin
          if (c == e) begin
            if (sp == 0) break;
            sp--; v = fv[sp]; c = fc[sp]; e = fe[sp];
          end else begin
            d = int'(mem[nb + c]);
            exp_s[exp_n] = v; exp_d[exp_n] = d; exp_n++;
            c++;
            if (!vis[d] && (sp + 1) < eb) begin
              fv[sp] = v; fc[sp] = c; fe[sp] = e; sp++;
              vis[d] = 1'b1; v = d;
              c = int'(mem[ob + d]); e = int'(mem[ob + d + 1]);
            end
          end
        end
      end
    end
  endtask

  task automatic run_case(input string tag, input int ob, input int nb, input int nv,
                          input int bd, input int bp, input int ne);
    int wait_c;
    build_ref(ob, nb, nv, bd);
    bp_mode = bp;
    got_n = 0; pf_n = 0; req_n = 0;
    @(negedge clk);
    cfg_ob = 16'(ob); cfg_nb = 16'(nb); cfg_nv = (VID_W+1)'(nv); cfg_bd = 8'(bd);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_c = 0;
    while (!(done && !edge_valid) && wait_c < 20000) begin
      @(negedge clk); wait_c++;
    end
    chk(wait_c < 20000, {tag, " R9 completion"}, wait_c, 0);
    chk(done && !busy, {tag, " R9 done/busy"}, int'({done, busy}), 2);
    chk(got_n == exp_n && exp_n == ne, {tag, " R4 edge count"}, got_n, ne);
    for (int i = 0; i < exp_n && i < got_n; i++) begin
      chk(got_s[i] == exp_s[i], {tag, " R3 edge src"}, got_s[i], exp_s[i]);
      chk(got_d[i] == exp_d[i], {tag, " R3 edge dst"}, got_d[i], exp_d[i]);
    end
    chk(pf_n == exp_n, {tag, " R5 prefetch count"}, pf_n, exp_n);
    for (int i = 0; i < exp_n && i < pf_n; i++)
      chk(pf_d[i] == exp_d[i], {tag, " R5 prefetch vertex"}, pf_d[i], exp_d[i]);
    chk(req_n == 2 * nv + ne, {tag, " R2 read count"}, req_n, 2 * nv + ne);
  endtask

  task automatic load_graph_a();
    int offs [9] = '{0, 2, 4, 5, 7, 9, 10, 11, 13};
    int nbrs [13] = '{1, 4, 2, 0, 3, 1, 5, 0, 6, 7, 4, 5, 3};
    for (int i = 0; i < 9; i++)  mem[16 + i] = 16'(offs[i]);
    for (int i = 0; i < 13; i++) mem[64 + i] = 16'(nbrs[i]);
  endtask

  task automatic load_graph_b();
    int offs [6] = '{0, 1, 2, 2, 3, 3};
    int nbrs [3] = '{3, 0, 1};
    for (int i = 0; i < 6; i++) mem[128 + i] = 16'(offs[i]);
    for (int i = 0; i < 3; i++) mem[160 + i] = 16'(nbrs[i]);
  endtask

  task automatic load_chain();
    for (int i = 0; i < 8; i++) mem[192 + i] = 16'(i);
    mem[200] = 16'd7;
    for (int i = 0; i < 7; i++) mem[224 + i] = 16'(i + 1);
  endtask

  task automatic test_reset();
    chk(!busy && !done, "R1 busy/done", int'({busy, done}), 0);
    chk(!edge_valid && !pf_valid, "R1 edge/pf", int'({edge_valid, pf_valid}), 0);
    chk(!rd_req_valid, "R1 read request", int'(rd_req_valid), 0);
  endtask

  task automatic test_empty();
    run_case("zero vertices", 16, 64, 0, 4, 0, 0);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog R9 actual=%0d expected=%0d", 150000, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = '0;
    start = 1'b0; cfg_ob = '0; cfg_nb = '0; cfg_nv = '0; cfg_bd = '0;
    edge_ready = 1'b1; rd_req_ready = 1'b1;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    test_reset();
    rst_n = 1'b1;
    @(negedge clk);
    test_reset();
    load_graph_a(); load_graph_b(); load_chain();
    run_case("bound4 R3", 16, 64, 8, 4, 0, 13);
    run_case("bound2 R3", 16, 64, 8, 2, 0, 13);
    run_case("bound1 R6", 16, 64, 8, 1, 0, 13);
    run_case("bound0 R6", 16, 64, 8, 0, 0, 13);
    run_case("backpressure R8", 16, 64, 8, 4, 1, 13);
    run_case("zero degree R9", 128, 160, 5, 3, 0, 3);
    run_case("clamp R7", 192, 224, 8, 15, 0, 7);
    run_case("clamp bp R8", 192, 224, 8, 200, 1, 7);
    test_empty();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule